// File: doc/BRIEF.md
# Dual-Processor Mailbox Port

This block lets two processors that share one clock pass bytes to each other through a single 8-bit mailbox. The master side writes a byte into an outgoing data register. The slave side sees that byte only while its decoded read term is active. When the term is inactive, the slave data bus is driven to zero and its valid flag is low, which stands in for a high-impedance port.

Traffic in the other direction uses separate storage. The slave writes into a bank of input cells, and these cells are clocked by a decoded slave write term. The master reads the cells directly. Each direction has a full flag that the receiving side can poll. It also has a sticky overrun flag that records a byte overwritten before it was read.

Writes on either side are always accepted; there is no back-pressure. A write strobe acts as a valid with an implied ready that is always high. A new byte replaces an unread one and raises the overrun flag. Slave bus timing is reduced to single-cycle strobes in the common clock domain.

Top module: `mbx_dual_port`

## Requirements
- R1: A synchronous active-high reset clears both data registers, both full flags and both overrun flags. After reset, `s_rdata` is 0, `s_rdata_valid` is 0 and `m_rdata` is 0.
- R2: A cycle with `m_wr` high stores `m_wdata` into the outgoing register, and `m2s_full` is 1 from the next cycle on.
- R3: The slave read term is `s_cs & s_rd & ~s_wr`. While it is high, `s_rdata` equals the outgoing register and `s_rdata_valid` is 1, in the same cycle. While it is low, `s_rdata` is 0 and `s_rdata_valid` is 0.
- R4: A clock edge with the slave read term high and no master write clears `m2s_full`. A clock edge with `m_rd` high and no slave write clears `s2m_full`.
- R5: The slave write term is `s_cs & s_wr`. On an edge where it is high, `s_wdata` is captured into the input cells and `s2m_full` becomes 1. A write strobe while `s_cs` is low changes nothing.
- R6: `m_rdata` always presents the input cell contents, whether or not `m_rd` is high. A master read does not change those contents.
- R7: A write on a side whose full flag is set, with no read of that direction on the same edge, replaces the byte and sets that direction's overrun flag. The overrun flag stays set until reset.
- R8: A write and a read of the same direction on the same edge store the new byte and leave the full flag at 1. The overrun flag is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| m_wr | input | 1 | Master write strobe |
| m_wdata | input | 8 | Master byte to send |
| m_rd | input | 1 | Master read strobe; acknowledges the input cells |
| m_rdata | output | 8 | Input cell contents, read directly by the master |
| s_cs | input | 1 | Slave chip select |
| s_rd | input | 1 | Slave read strobe |
| s_wr | input | 1 | Slave write strobe |
| s_wdata | input | 8 | Slave byte to send |
| s_rdata | output | 8 | Outgoing byte while the read term is active, else 0 |
| s_rdata_valid | output | 1 | High while the slave read term is active |
| m2s_full | output | 1 | Unread byte waiting for the slave |
| s2m_full | output | 1 | Unread byte waiting for the master |
| m2s_overrun | output | 1 | Sticky: master overwrote an unread byte |
| s2m_overrun | output | 1 | Sticky: slave overwrote an unread byte |

## Verification
Several behaviours are checked by assertions on every cycle:
- After a write, the full flag is set on the next cycle.
- A pure read clears the full flag.
- The overrun flag is sticky, and it rises only after a write into a full, unread slot.
- The slave bus is zero whenever it is not valid.
- The input cells hold still while chip select is low.

Other behaviours depend on specific data values and only the bench scenarios can show them:
- The master's byte reaches the slave.
- A strobe without chip select or with both strobes high is rejected.
- The overwritten byte is the one that remains visible.
- A write and a read on the same edge leave the flag full without an overrun.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DEF_WIDTH = 8;

  typedef struct packed {
    logic rd_term;
    logic wr_term;
  } mbx_term_t;
endpackage

// File: rtl/mbx_strobe_decode.sv
module mbx_strobe_decode
  import mbx_pkg::*;
(
  input  logic      cs_i,
  input  logic      rd_i,
  input  logic      wr_i,
  output mbx_term_t term_o
);
  // Read needs select and read strobe without a concurrent write strobe.
  always_comb begin
    term_o.rd_term = cs_i & rd_i & ~wr_i;
    term_o.wr_term = cs_i & wr_i;
  end

  // R3/R5: read and write terms are mutually exclusive
  always_comb begin
    assert_terms_exclusive_R3: assert (!(term_o.rd_term && term_o.wr_term));
  end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             overrun_o
);
  logic [WIDTH-1:0] data_q;
  logic             full_q;
  logic             ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        data_q <= wr_data_i;
        full_q <= 1'b1;
        if (full_q && !rd_i) ovr_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign data_o    = data_q;
  assign full_o    = full_q;
  assign overrun_o = ovr_q;

  assert_full_after_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> full_o);

  assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !wr_i) |=> !full_o);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_o) |-> $past(wr_i && full_o && !rd_i));

  assert_no_overrun_on_swap_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_i && rd_i && !overrun_o) |=> !overrun_o);
endmodule

// File: rtl/mbx_dual_port.sv
module mbx_dual_port
  import mbx_pkg::*;
#(
  parameter int unsigned WIDTH = MBX_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             m_wr,
  input  logic [WIDTH-1:0] m_wdata,
  input  logic             m_rd,
  output logic [WIDTH-1:0] m_rdata,
  input  logic             s_cs,
  input  logic             s_rd,
  input  logic             s_wr,
  input  logic [WIDTH-1:0] s_wdata,
  output logic [WIDTH-1:0] s_rdata,
  output logic             s_rdata_valid,
  output logic             m2s_full,
  output logic             s2m_full,
  output logic             m2s_overrun,
  output logic             s2m_overrun
);
  mbx_term_t        slv_term;
  logic [WIDTH-1:0] out_reg;

  mbx_strobe_decode u_decode (
    .cs_i   (s_cs),
    .rd_i   (s_rd),
    .wr_i   (s_wr),
    .term_o (slv_term)
  );

  // Master-to-slave: outgoing data register, consumed by the slave read term.
  mbx_channel #(.WIDTH(WIDTH)) u_m2s (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (m_wr),
    .wr_data_i (m_wdata),
    .rd_i      (slv_term.rd_term),
    .data_o    (out_reg),
    .full_o    (m2s_full),
    .overrun_o (m2s_overrun)
  );

  // Slave-to-master: input cells clocked by the slave write term.
  mbx_channel #(.WIDTH(WIDTH)) u_s2m (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (slv_term.wr_term),
    .wr_data_i (s_wdata),
    .rd_i      (m_rd),
    .data_o    (m_rdata),
    .full_o    (s2m_full),
    .overrun_o (s2m_overrun)
  );

  // Output enable: zero and not valid stands in for a floating bus.
  assign s_rdata_valid = slv_term.rd_term;
  assign s_rdata       = slv_term.rd_term ? out_reg : '0;

  assert_bus_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !s_rdata_valid |-> (s_rdata == '0));

  assert_cells_hold_without_cs_R5: assert property (@(posedge clk) disable iff (rst)
    !s_cs |=> $stable(m_rdata));

  assert_master_read_keeps_cells_R6: assert property (@(posedge clk) disable iff (rst)
    (m_rd && !s_cs) |=> $stable(m_rdata));
endmodule

// File: tb/mbx_dual_port_tb_top.sv
module mbx_dual_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       m_wr, m_rd, s_cs, s_rd, s_wr;
  logic [7:0] m_wdata, s_wdata;
  logic [7:0] m_rdata, s_rdata;
  logic       s_rdata_valid, m2s_full, s2m_full, m2s_overrun, s2m_overrun;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_dual_port dut_i (
    .clk(clk), .rst(rst),
    .m_wr(m_wr), .m_wdata(m_wdata), .m_rd(m_rd), .m_rdata(m_rdata),
    .s_cs(s_cs), .s_rd(s_rd), .s_wr(s_wr), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_rdata_valid(s_rdata_valid),
    .m2s_full(m2s_full), .s2m_full(s2m_full),
    .m2s_overrun(m2s_overrun), .s2m_overrun(s2m_overrun)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    m_wr = 0; m_rd = 0; s_cs = 0; s_rd = 0; s_wr = 0;
    m_wdata = 8'h00; s_wdata = 8'h00;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    idle();
    rst = 1;
    tick(); tick();
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 s_rdata", s_rdata, 8'h00);
    chk("R1 valid", {7'b0, s_rdata_valid}, 8'h00);
    chk("R1 m_rdata", m_rdata, 8'h00);
    chk("R1 flags", {4'b0, m2s_full, s2m_full, m2s_overrun, s2m_overrun}, 8'h00);
  endtask

  task automatic t_master_to_slave();
    m_wr = 1; m_wdata = 8'hA5;
    tick();
    idle();
    chk("R2 m2s_full", {7'b0, m2s_full}, 8'h01);
    chk("R3 idle bus zero", s_rdata, 8'h00);
    s_rd = 1; #1;
    chk("R3 no cs valid", {7'b0, s_rdata_valid}, 8'h00);
    s_cs = 1; s_rd = 1; #1;
    chk("R3 read data", s_rdata, 8'hA5);
    chk("R3 read valid", {7'b0, s_rdata_valid}, 8'h01);
    tick();
    idle();
    chk("R4 m2s_full cleared", {7'b0, m2s_full}, 8'h00);
  endtask

  task automatic t_rd_wr_conflict();
    m_wr = 1; m_wdata = 8'h77;
    tick();
    idle();
    s_cs = 1; s_rd = 1; s_wr = 1; s_wdata = 8'h99; #1;
    chk("R3 both strobes not valid", {7'b0, s_rdata_valid}, 8'h00);
    chk("R3 both strobes bus zero", s_rdata, 8'h00);
    tick();
    idle();
    chk("R3 m2s still full", {7'b0, m2s_full}, 8'h01);
    chk("R5 write term took byte", m_rdata, 8'h99);
    m_rd = 1; s_cs = 1; s_rd = 1;
    tick();
    idle();
  endtask

  task automatic t_slave_to_master();
    do_reset();
    s_wr = 1; s_wdata = 8'hEE;
    tick();
    idle();
    chk("R5 no cs ignored data", m_rdata, 8'h00);
    chk("R5 no cs ignored flag", {7'b0, s2m_full}, 8'h00);
    s_cs = 1; s_wr = 1; s_wdata = 8'h3C;
    tick();
    idle();
    chk("R5 captured", m_rdata, 8'h3C);
    chk("R5 s2m_full", {7'b0, s2m_full}, 8'h01);
    m_rd = 1;
    tick();
    idle();
    chk("R4 s2m_full cleared", {7'b0, s2m_full}, 8'h00);
    chk("R6 data kept after read", m_rdata, 8'h3C);
  endtask

  task automatic t_overrun();
    do_reset();
    m_wr = 1; m_wdata = 8'h11;
    tick();
    m_wdata = 8'h22;
    tick();
    idle();
    chk("R7 m2s overrun", {7'b0, m2s_overrun}, 8'h01);
    s_cs = 1; s_rd = 1; #1;
    chk("R7 newest byte", s_rdata, 8'h22);
    tick();
    idle();
    tick();
    chk("R7 sticky", {7'b0, m2s_overrun}, 8'h01);
    s_cs = 1; s_wr = 1; s_wdata = 8'h01;
    tick();
    s_wdata = 8'h02;
    tick();
    idle();
    chk("R7 s2m overrun", {7'b0, s2m_overrun}, 8'h01);
    chk("R7 s2m newest", m_rdata, 8'h02);
    do_reset();
    chk("R7 reset clears", {6'b0, m2s_overrun, s2m_overrun}, 8'h00);
  endtask

  task automatic t_simultaneous();
    do_reset();
    s_cs = 1; s_wr = 1; s_wdata = 8'h44;
    tick();
    s_wdata = 8'h55; m_rd = 1;
    tick();
    idle();
    chk("R8 s2m full kept", {7'b0, s2m_full}, 8'h01);
    chk("R8 s2m no overrun", {7'b0, s2m_overrun}, 8'h00);
    chk("R8 s2m new byte", m_rdata, 8'h55);
    m_wr = 1; m_wdata = 8'h66;
    tick();
    m_wdata = 8'h67; s_cs = 1; s_rd = 1;
    tick();
    idle();
    chk("R8 m2s full kept", {7'b0, m2s_full}, 8'h01);
    chk("R8 m2s no overrun", {7'b0, m2s_overrun}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1;
    idle();
    t_reset();
    t_master_to_slave();
    t_rd_wr_conflict();
    t_slave_to_master();
    t_overrun();
    t_simultaneous();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule